// File: doc/BRIEF.md
# Serial Port Buffer and Interrupt Controller

This block sits between the register interface and the shift engine of a synchronous serial port. It holds two independent first-in first-out buffers. The transmit buffer is written from the register side and drained by the engine. The receive buffer is filled by the engine and drained from the register side. Each buffer is 16 bits wide and 8 entries deep.

Three interrupt sources come from the buffer state:

- **Transmit service request.** Active while the transmit buffer runs low.
- **Receive service request.** Active while the receive buffer fills up.
- **Receive overrun.** A sticky flag. It is set when the engine delivers a word into a full receive buffer, and stays set until software strobes a clear input.

Each source has its own enable input and its own gated output. A combined line reports whenever any gated source is active. Full and empty flags of both buffers are brought out as status. Bus decode and serial shifting belong to neighbouring blocks.

Top module: `ssp_fifo_irq`

## Requirements
- R1: After reset both buffers are empty and not full, and the overrun flag is clear. With all enables at 1, `irq_tx`=1, `irq_rx`=0, `irq_ovr`=0 and `irq_any`=1.
- R2: Words written through `tx_wr` reach `eng_tx_rdata` in write order with all 16 bits intact. `tx_full` rises after the 8th unread word.
- R3: A `tx_wr` while `tx_full`=1 is ignored. An `eng_tx_rd` while `tx_empty`=1 shows 0 on `eng_tx_rdata` and changes no state.
- R4: Words written through `eng_rx_wr` reach `rx_rdata` in order. A `rx_rd` while `rx_empty`=1 shows 0 and leaves the buffer empty.
- R5: The raw transmit request is 1 exactly while the transmit buffer holds 4 or fewer words.
- R6: The raw receive request is 1 exactly while the receive buffer holds 4 or more words.
- R7: An `eng_rx_wr` while `rx_full`=1 sets the overrun flag from the next cycle on. The incoming word is dropped and the 8 stored words are kept.
- R8: The overrun flag holds until a cycle with `ovr_clr`=1 and no new overrun. An overrun in the same cycle as `ovr_clr` leaves it set.
- R9: Each of `irq_tx`, `irq_rx`, `irq_ovr` equals its raw source ANDed with its enable input. An enable of 1 passes the source; an enable of 0 blocks it.
- R10: `irq_any` is 1 exactly when at least one of `irq_tx`, `irq_rx`, `irq_ovr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| tx_wr | input | 1 | Register-side push into the transmit buffer |
| tx_wdata | input | 16 | Word to push |
| eng_tx_rd | input | 1 | Engine pop from the transmit buffer |
| eng_tx_rdata | output | 16 | Head of the transmit buffer (0 when empty) |
| eng_rx_wr | input | 1 | Engine push into the receive buffer |
| eng_rx_wdata | input | 16 | Received word |
| rx_rd | input | 1 | Register-side pop from the receive buffer |
| rx_rdata | output | 16 | Head of the receive buffer (0 when empty) |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| en_tx | input | 1 | Enable of the transmit request |
| en_rx | input | 1 | Enable of the receive request |
| en_ovr | input | 1 | Enable of the overrun interrupt |
| irq_tx | output | 1 | Gated transmit request |
| irq_rx | output | 1 | Gated receive request |
| irq_ovr | output | 1 | Gated overrun interrupt |
| irq_any | output | 1 | OR of the gated interrupts |
| tx_full | output | 1 | Transmit buffer full |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer full |
| rx_empty | output | 1 | Receive buffer empty |

## Verification
Distinct word patterns are pushed until each buffer fills, including a word that must be dropped. Comparing the drained order separates correct sequencing from pointer wrap or overwrite faults. The fill level is stepped across the thresholds of 4 one word at a time, which catches off-by-one comparisons on either request. Overrun is provoked alone, together with a clear in the same cycle, and with the clear alone, to tell set priority from stickiness. The enables are then toggled one by one with every source active, which exposes swapped or missing gates on the individual outputs and on the combined line.

// File: rtl/ssp_buf_pkg.sv
package ssp_buf_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned BUF_DEPTH  = 8;
  localparam int unsigned TX_LOW_LVL = 4;
  localparam int unsigned RX_HI_LVL  = 4;

  typedef struct packed {
    logic tx;
    logic rx;
    logic ovr;
  } irq_src_t;
endpackage

// File: rtl/ssp_sfifo.sv
module ssp_sfifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          wr_drop
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          wr_ok, rd_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ok   = wr && !full;
  assign rd_ok   = rd && !empty;
  assign wr_drop = wr && full;
  assign count   = cnt_q;
  assign rdata   = empty ? '0 : mem_q[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (wr_ok) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (rd_ok) rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (wr_ok && !rd_ok) cnt_n = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= wdata;
  end

  // R2: occupancy never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3: a push into a full buffer without a pop leaves occupancy unchanged
  p_full_push_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> (full && cnt_q == $past(cnt_q)));
  // R4: a pop from an empty buffer without a push keeps it empty
  p_empty_pop_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd && !wr) |=> empty);
endmodule

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl
  import ssp_buf_pkg::*;
#(
  parameter int unsigned CW     = 4,
  parameter int unsigned TX_LVL = 4,
  parameter int unsigned RX_LVL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          ovr_event,
  input  logic          ovr_clr,
  input  irq_src_t      en,
  output irq_src_t      irq,
  output logic          irq_any
);
  irq_src_t raw;
  logic     ovr_q, ovr_n;

  always_comb begin
    ovr_n = ovr_q;
    if (ovr_event)    ovr_n = 1'b1;
    else if (ovr_clr) ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_n;
  end

  always_comb begin
    raw.tx  = (tx_count <= CW'(TX_LVL));
    raw.rx  = (rx_count >= CW'(RX_LVL));
    raw.ovr = ovr_q;
    irq     = raw & en;
    irq_any = |irq;
  end

  // R7: an overrun event sets the flag on the following cycle
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> ovr_q);
  // R8: without a clear strobe the flag cannot fall
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q);
  // R9: a disabled source never reaches its output
  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en.tx -> !irq.tx) && (!en.rx -> !irq.rx) && (!en.ovr -> !irq.ovr)));
endmodule

// File: rtl/ssp_fifo_irq.sv
module ssp_fifo_irq
  import ssp_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              eng_tx_rd,
  output logic [WORD_W-1:0] eng_tx_rdata,
  input  logic              eng_rx_wr,
  input  logic [WORD_W-1:0] eng_rx_wdata,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_rdata,
  input  logic              ovr_clr,
  input  logic              en_tx,
  input  logic              en_rx,
  input  logic              en_ovr,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr,
  output logic              irq_any,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty
);
  localparam int unsigned CW = $clog2(BUF_DEPTH + 1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_drop_unused, rx_drop;
  irq_src_t      en_v, irq_v;

  ssp_sfifo #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .wr(tx_wr), .wdata(tx_wdata),
    .rd(eng_tx_rd), .rdata(eng_tx_rdata),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .wr_drop(tx_drop_unused)
  );

  ssp_sfifo #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .wr(eng_rx_wr), .wdata(eng_rx_wdata),
    .rd(rx_rd), .rdata(rx_rdata),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .wr_drop(rx_drop)
  );

  assign en_v = '{tx: en_tx, rx: en_rx, ovr: en_ovr};

  ssp_irq_ctrl #(.CW(CW), .TX_LVL(TX_LOW_LVL), .RX_LVL(RX_HI_LVL)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_count(tx_cnt), .rx_count(rx_cnt),
    .ovr_event(rx_drop), .ovr_clr(ovr_clr),
    .en(en_v), .irq(irq_v), .irq_any(irq_any)
  );

  assign irq_tx  = irq_v.tx;
  assign irq_rx  = irq_v.rx;
  assign irq_ovr = irq_v.ovr;

  // R7: a push into a full receive buffer keeps it full when nothing is popped
  p_rx_kept_on_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && eng_rx_wr && !rx_rd) |=> rx_full);
  // R7: the enabled overrun output follows one cycle after a dropped word
  p_ovr_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && eng_rx_wr && en_ovr) |=> (irq_ovr || !en_ovr));
  // R10: any individual interrupt implies the combined line
  p_any_covers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx || irq_rx || irq_ovr) |-> irq_any);
endmodule

// File: tb/tb_ssp_fifo_irq.sv
`timescale 1ns/1ps
module tb_ssp_fifo_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_wr, eng_tx_rd, eng_rx_wr, rx_rd, ovr_clr;
  logic [15:0] tx_wdata, eng_rx_wdata, eng_tx_rdata, rx_rdata;
  logic        en_tx, en_rx, en_ovr;
  logic        irq_tx, irq_rx, irq_ovr, irq_any;
  logic        tx_full, tx_empty, rx_full, rx_empty;

  int checks = 0;
  int fails  = 0;
  logic [15:0] q_tx[$];
  logic [15:0] q_rx[$];

  always #4 clk = ~clk;

  ssp_fifo_irq dut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: push into transmit buffer, record expectation when accepted
  task automatic drv_tx(logic [15:0] d);
    if (!tx_full) q_tx.push_back(d);
    tx_wr = 1'b1; tx_wdata = d;
    @(posedge clk); #1;
    tx_wr = 1'b0;
  endtask

  task automatic drv_rx(logic [15:0] d);
    if (!rx_full) q_rx.push_back(d);
    eng_rx_wr = 1'b1; eng_rx_wdata = d;
    @(posedge clk); #1;
    eng_rx_wr = 1'b0;
  endtask

  // monitor: pop from the design and compare against the scoreboard
  task automatic mon_tx(string tag);
    logic [15:0] exp;
    exp = (q_tx.size() == 0) ? 16'h0 : q_tx.pop_front();
    eng_tx_rd = 1'b1; #1;
    chk(tag, eng_tx_rdata, exp);
    @(posedge clk); #1;
    eng_tx_rd = 1'b0;
  endtask

  task automatic mon_rx(string tag);
    logic [15:0] exp;
    exp = (q_rx.size() == 0) ? 16'h0 : q_rx.pop_front();
    rx_rd = 1'b1; #1;
    chk(tag, rx_rdata, exp);
    @(posedge clk); #1;
    rx_rd = 1'b0;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_wr = 0; eng_tx_rd = 0; eng_rx_wr = 0; rx_rd = 0; ovr_clr = 0;
    tx_wdata = 0; eng_rx_wdata = 0;
    en_tx = 1; en_rx = 1; en_ovr = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 tx_empty", 16'(tx_empty), 16'h1);
    chk("R1 rx_empty", 16'(rx_empty), 16'h1);
    chk("R1 fulls", {tx_full, rx_full}, 16'h0);
    chk("R1 irqs", {irq_tx, irq_rx, irq_ovr, irq_any}, 16'b1001);

    // R5 transmit threshold stepped across 4
    for (int i = 0; i < 4; i++) drv_tx(16'hA000 + 16'(i * 16'h111));
    chk("R5 tx request at 4", 16'(irq_tx), 16'h1);
    drv_tx(16'h5A5A);
    chk("R5 tx request at 5", 16'(irq_tx), 16'h0);
    drv_tx(16'hFFFF); drv_tx(16'h0001); drv_tx(16'h8000);
    chk("R2 tx_full at 8", 16'(tx_full), 16'h1);
    drv_tx(16'hDEAD);
    chk("R3 full push ignored", 16'(tx_full), 16'h1);

    // R2 drain in order; R5 recovers at 4
    for (int i = 0; i < 4; i++) mon_tx("R2 tx order");
    chk("R5 tx request at 4 after drain", 16'(irq_tx), 16'h1);
    for (int i = 0; i < 4; i++) mon_tx("R2 tx order");
    chk("R2 tx_empty after drain", 16'(tx_empty), 16'h1);
    mon_tx("R3 empty engine read");
    chk("R3 still empty", 16'(tx_empty), 16'h1);

    // R6 receive threshold
    for (int i = 0; i < 3; i++) drv_rx(16'h1230 + 16'(i));
    chk("R6 rx request at 3", 16'(irq_rx), 16'h0);
    drv_rx(16'hC3C3);
    chk("R6 rx request at 4", 16'(irq_rx), 16'h1);
    for (int i = 0; i < 4; i++) drv_rx(16'h7000 + 16'(i * 16'h0F0F));
    chk("R4 rx_full at 8", 16'(rx_full), 16'h1);
    chk("R7 no overrun yet", 16'(irq_ovr), 16'h0);
    drv_rx(16'hBAD0);
    chk("R7 overrun set", 16'(irq_ovr), 16'h1);
    chk("R10 any with overrun", 16'(irq_any), 16'h1);

    // R7 stored words preserved, R4 order
    for (int i = 0; i < 8; i++) mon_rx("R7 rx contents preserved");
    chk("R4 rx_empty", 16'(rx_empty), 16'h1);
    mon_rx("R4 empty register read");
    chk("R4 still empty", 16'(rx_empty), 16'h1);
    chk("R8 overrun held", 16'(irq_ovr), 16'h1);
    ovr_clr = 1; @(posedge clk); #1; ovr_clr = 0;
    chk("R8 cleared by strobe", 16'(irq_ovr), 16'h0);

    // R8 clear coincident with new overrun
    for (int i = 0; i < 8; i++) drv_rx(16'h4400 + 16'(i));
    ovr_clr = 1;
    drv_rx(16'hEEEE);
    ovr_clr = 0;
    chk("R8 set wins over clear", 16'(irq_ovr), 16'h1);

    // R9 / R10 enables, with tx empty, rx full, overrun set
    en_tx = 0; #1;
    chk("R9 tx blocked", {irq_tx, irq_rx, irq_ovr}, 16'b011);
    en_rx = 0; #1;
    chk("R9 rx blocked", {irq_tx, irq_rx, irq_ovr}, 16'b001);
    chk("R10 any from ovr only", 16'(irq_any), 16'h1);
    en_ovr = 0; #1;
    chk("R10 any low when all blocked", 16'(irq_any), 16'h0);
    en_tx = 1; #1;
    chk("R9 tx passes alone", {irq_tx, irq_rx, irq_ovr, irq_any}, 16'b1001);
    @(posedge clk); #1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule